// File: doc/BRIEF.md
# Integer Tile Multiply-Accumulate Unit

This block takes two 256-bit operand registers and a set of four 256-bit accumulator registers, multiplies the two operand tiles as small integer matrices and adds the product into the accumulator tile. Every operand is read as four rows. Row `r` of any register sits in bits `[64r+63:64r]`, and the element size sets how many columns each row holds. In the narrow mode, a 4×8 tile of signed bytes is multiplied by an 8×4 tile of signed bytes. The 4×4 result of 32-bit sums is added into accumulator registers 0 and 1. In the wide mode, two 4×4 tiles of signed 16-bit values are multiplied and the result is added into a 4×4 tile of 64-bit sums spread across all four accumulator registers.

The right operand arrives in row form. Its row `c` holds column `c` of the weight matrix, so the weights are transposed where they enter the multiplier. The unit is pipelined with two register stages and can take a new operation on every cycle. Each result appears exactly two cycles after its request. The caller feeds the result back as the next accumulator input when it chains several operations.

Top module: `tile_mac_unit`

## Requirements
- R1: While `rstN` is low, and after it is released until the first result, `outValid` is 0 and `accOut` is all zeros.
- R2: A request with `inValid`=1 sampled at clock edge N produces `outValid`=1 at edge N+2, together with its result. A request may come on every cycle, and back-to-back results come out in request order on consecutive cycles.
- R3: With `modeWide`=0 (narrow mode), element (r,k) of the left tile is the signed byte `lhsReg[64r+8k+7:64r+8k]` for k=0..7. The result C[r][c] = acc[r][c] + Σk A[r][k]·W[k][c].
- R4: In narrow mode, weight W[k][c] is the signed byte `rhsReg[64c+8k+7:64c+8k]`, so rhs row c supplies column c of the weights.
- R5: In narrow mode, 32-bit entry (r,c) lives in accumulator register c/2 (register i is `accIn[256i+255:256i]`), at bit offset 64r+32·(c mod 2) within it. Registers 2 and 3 pass to `accOut` unchanged.
- R6: With `modeWide`=1, A[r][k] is the signed 16-bit value at bits 64r+16k of `lhsReg` and W[k][c] is the signed 16-bit value at bits 64c+16k of `rhsReg`. The 64-bit entry (r,c) sits in register c at bits 64r..64r+63, and C = acc + A·W.
- R7: All multiplicands are two's complement. An all −128 narrow product adds 131072 to each entry, and an all −32768 wide product adds 2^32 to each entry.
- R8: Accumulation wraps modulo the accumulator width, 2^32 in narrow mode and 2^64 in wide mode, with no saturation.
- R9: In a cycle with no result, `outValid` is 0 and `accOut` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation request this cycle |
| modeWide | input | 1 | 0 = signed 8-bit / 32-bit acc, 1 = signed 16-bit / 64-bit acc |
| lhsReg | input | 256 | Left (activation) tile |
| rhsReg | input | 256 | Right (weight) tile, one weight column per row |
| accIn | input | 1024 | Four accumulator registers, register i at [256i+255:256i] |
| outValid | output | 1 | Result present on accOut |
| accOut | output | 1024 | Updated accumulator registers |

## Verification
The case that matters most is a result being committed in the same cycle that the next request is captured, especially when the two use different modes. The risk is that the mode or accumulator of one operation leaks into its neighbour. To provoke it, the bench issues requests on consecutive cycles with the modes alternating. It then checks each result against a reference model computed only from that request's own inputs, in request order. Holding across idle cycles is also judged: an idle cycle directly after a commit must leave `accOut` untouched.

// File: rtl/tile_mac_pkg.sv
package tile_mac_pkg;
  localparam int ROWS     = 4;
  localparam int LANE_W   = 64;
  localparam int REG_W    = ROWS * LANE_W;
  localparam int ACC_REGS = 4;
  localparam int ACC_W    = REG_W * ACC_REGS;
  localparam int NARROW_E = 8;
  localparam int WIDE_E   = 16;
  localparam int NARROW_K = LANE_W / NARROW_E;
  localparam int WIDE_K   = LANE_W / WIDE_E;

  typedef struct packed {
    logic captureOp;
    logic commitOp;
  } macCtrl_t;

  function automatic logic signed [63:0] laneDot(input logic wide,
                                                 input logic [LANE_W-1:0] a,
                                                 input logic [LANE_W-1:0] b);
    logic signed [63:0] s;
    s = '0;
    if (wide) begin
      for (int k = 0; k < WIDE_K; k++)
        s = s + 64'($signed(a[WIDE_E*k +: WIDE_E])) * 64'($signed(b[WIDE_E*k +: WIDE_E]));
    end else begin
      for (int k = 0; k < NARROW_K; k++)
        s = s + 64'($signed(a[NARROW_E*k +: NARROW_E])) * 64'($signed(b[NARROW_E*k +: NARROW_E]));
    end
    return s;
  endfunction
endpackage

// File: rtl/tile_mac_ctrl.sv
module tile_mac_ctrl
  import tile_mac_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output macCtrl_t ctrl,
  output logic     outValid
);
  logic stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      outValid    <= stage1Valid;
    end
  end

  assign ctrl.captureOp = inValid;
  assign ctrl.commitOp  = stage1Valid;
endmodule

// File: rtl/tile_mac_datapath.sv
module tile_mac_datapath
  import tile_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  macCtrl_t         ctrl,
  input  logic             modeWide,
  input  logic [REG_W-1:0] lhsReg,
  input  logic [REG_W-1:0] rhsReg,
  input  logic [ACC_W-1:0] accIn,
  output logic [ACC_W-1:0] accOut
);
  logic signed [63:0] dotNow [ROWS][ACC_REGS];
  logic signed [63:0] dotQ   [ROWS][ACC_REGS];
  logic [ACC_W-1:0]   accQ;
  logic               wideQ;
  logic [ACC_W-1:0]   accNext;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < ACC_REGS; c++) begin : g_col
      assign dotNow[r][c] = laneDot(modeWide, lhsReg[LANE_W*r +: LANE_W],
                                    rhsReg[LANE_W*c +: LANE_W]);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               dotQ[r][c] <= '0;
        else if (ctrl.captureOp) dotQ[r][c] <= dotNow[r][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      wideQ <= 1'b0;
    end else if (ctrl.captureOp) begin
      accQ  <= accIn;
      wideQ <= modeWide;
    end
  end

  for (genvar i = 0; i < ACC_REGS; i++) begin : g_reg
    for (genvar r = 0; r < ROWS; r++) begin : g_quarter
      localparam int BASE = REG_W*i + LANE_W*r;
      if (i < 2) begin : g_shared
        always_comb begin
          if (wideQ) begin
            accNext[BASE +: 64] = accQ[BASE +: 64] + dotQ[r][i];
          end else begin
            accNext[BASE +: 32]      = accQ[BASE +: 32]      + dotQ[r][2*i][31:0];
            accNext[BASE + 32 +: 32] = accQ[BASE + 32 +: 32] + dotQ[r][2*i+1][31:0];
          end
        end
      end else begin : g_wideOnly
        always_comb begin
          if (wideQ) accNext[BASE +: 64] = accQ[BASE +: 64] + dotQ[r][i];
          else       accNext[BASE +: 64] = accQ[BASE +: 64];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              accOut <= '0;
    else if (ctrl.commitOp) accOut <= accNext;
  end
endmodule

// File: rtl/tile_mac_unit.sv
module tile_mac_unit
  import tile_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             modeWide,
  input  logic [REG_W-1:0] lhsReg,
  input  logic [REG_W-1:0] rhsReg,
  input  logic [ACC_W-1:0] accIn,
  output logic             outValid,
  output logic [ACC_W-1:0] accOut
);
  macCtrl_t ctrl;

  tile_mac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ctrl(ctrl), .outValid(outValid)
  );

  tile_mac_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .modeWide(modeWide),
    .lhsReg(lhsReg), .rhsReg(rhsReg), .accIn(accIn), .accOut(accOut)
  );
endmodule

// File: rtl/tile_mac_chk.sv
module tile_mac_chk
  import tile_mac_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             modeWide,
  input logic [REG_W-1:0] rhsReg,
  input logic [ACC_W-1:0] accIn,
  input logic             outValid,
  input logic [ACC_W-1:0] accOut
);
  logic             vld1, vld2, wide1, wide2, zero1, zero2;
  logic [ACC_W-1:0] acc1, acc2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld1 <= 1'b0; vld2 <= 1'b0; wide1 <= 1'b0; wide2 <= 1'b0;
      zero1 <= 1'b0; zero2 <= 1'b0; acc1 <= '0; acc2 <= '0;
    end else begin
      vld1  <= inValid;        vld2  <= vld1;
      wide1 <= modeWide;       wide2 <= wide1;
      zero1 <= (rhsReg == '0); zero2 <= zero1;
      acc1  <= accIn;          acc2  <= acc1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |-> (!outValid && accOut == '0)); // R1
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN) outValid == vld2); // R2
  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !wide2) |-> accOut[ACC_W-1:2*REG_W] == acc2[ACC_W-1:2*REG_W]); // R5
  AST_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zero2) |-> accOut == acc2); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(accOut)); // R9
endmodule

bind tile_mac_unit tile_mac_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .modeWide(modeWide), .rhsReg(rhsReg),
  .accIn(accIn), .outValid(outValid), .accOut(accOut)
);

// File: tb/sim_tile_mac_unit.sv
module sim_tile_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 256;
  localparam int AW = 1024;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          modeWide = 1'b0;
  logic [RW-1:0] lhsReg = '0;
  logic [RW-1:0] rhsReg = '0;
  logic [AW-1:0] accIn = '0;
  logic          outValid;
  logic [AW-1:0] accOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_mac_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeWide(modeWide),
    .lhsReg(lhsReg), .rhsReg(rhsReg), .accIn(accIn),
    .outValid(outValid), .accOut(accOut)
  );

  function automatic logic [AW-1:0] model(input logic wide, input logic [RW-1:0] a,
                                          input logic [RW-1:0] b, input logic [AW-1:0] acc);
    logic [AW-1:0] res;
    res = acc;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        if (wide) begin
          longint s;
          s = longint'(acc[256*c + 64*r +: 64]);
          for (int k = 0; k < 4; k++)
            s += longint'($signed(a[64*r + 16*k +: 16])) * longint'($signed(b[64*c + 16*k +: 16]));
          res[256*c + 64*r +: 64] = s;
        end else begin
          int s;
          int pos;
          pos = 256*(c/2) + 64*r + 32*(c%2);
          s = int'(acc[pos +: 32]);
          for (int k = 0; k < 8; k++)
            s += int'($signed(a[64*r + 8*k +: 8])) * int'($signed(b[64*c + 8*k +: 8]));
          res[pos +: 32] = s;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [RW-1:0] rnd256();
    logic [RW-1:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [AW-1:0] rnd1024();
    logic [AW-1:0] v;
    for (int i = 0; i < 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request at a negedge, check latency, result and hold.
  task automatic runOp(input logic wide, input logic [RW-1:0] a, input logic [RW-1:0] b,
                       input logic [AW-1:0] acc, input string req, output logic [AW-1:0] got);
    logic [AW-1:0] exp;
    exp = model(wide, a, b, acc);
    modeWide = wide; lhsReg = a; rhsReg = b; accIn = acc; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b0, "R2 early", AW'(outValid), '0);
    @(negedge clk);
    check(outValid == 1'b1, "R2 valid", AW'(outValid), AW'(1));
    check(accOut == exp, req, accOut, exp);
    got = accOut;
    lhsReg = rnd256(); rhsReg = rnd256(); accIn = rnd1024();
    @(negedge clk);
    check(outValid == 1'b0 && accOut == got, "R9 hold", accOut, got);
  endtask

  task automatic testReset();
    check(outValid == 1'b0 && accOut == '0, "R1 in reset", accOut, '0);
    @(negedge clk); rstN = 1'b1; @(negedge clk);
    check(outValid == 1'b0 && accOut == '0, "R1 after reset", accOut, '0);
  endtask

  task automatic testNarrow();
    logic [AW-1:0] got;
    logic [RW-1:0] a, b;
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 8; k++) begin
        a[64*r + 8*k +: 8] = 8'(r + k + 1);
        b[64*r + 8*k +: 8] = 8'(k - 2*r);
      end
    runOp(1'b0, a, b, rnd1024(), "R3 narrow pattern", got);
  endtask

  task automatic testTranspose();
    logic [AW-1:0] got;
    logic [RW-1:0] a, b;
    a = '0;
    for (int r = 0; r < 4; r++) a[64*r + 8*r +: 8] = 8'd1;
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 8; k++) b[64*c + 8*k +: 8] = 8'(16*c + k);
    runOp(1'b0, a, b, '0, "R4 transpose", got);
    // entry (r=1,c=2) = W[1][2] = byte k=1 of rhs row 2 = 33, in register 1 low half of quarter 1
    check(got[256 + 64 + 0 +: 32] == 32'd33, "R4 entry(1,2)", AW'(got[256+64 +: 32]), AW'(33));
  endtask

  task automatic testPassthrough();
    logic [AW-1:0] got;
    logic [AW-1:0] acc;
    acc = rnd1024();
    runOp(1'b0, rnd256(), rnd256(), acc, "R5 narrow layout", got);
    check(got[AW-1:512] == acc[AW-1:512], "R5 upper regs", AW'(got[AW-1:512]), AW'(acc[AW-1:512]));
  endtask

  task automatic testWide();
    logic [AW-1:0] got;
    for (int i = 0; i < 3; i++) runOp(1'b1, rnd256(), rnd256(), rnd1024(), "R6 wide", got);
  endtask

  task automatic testCorners();
    logic [AW-1:0] got;
    runOp(1'b0, {32{8'h80}}, {32{8'h80}}, '0, "R7 narrow -128", got);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        check(got[256*(c/2) + 64*r + 32*(c%2) +: 32] == 32'd131072, "R7 narrow entry",
              AW'(got[256*(c/2) + 64*r + 32*(c%2) +: 32]), AW'(131072));
    runOp(1'b1, {16{16'h8000}}, {16{16'h8000}}, '0, "R7 wide -32768", got);
    check(got[0 +: 64] == 64'h1_0000_0000, "R7 wide entry", AW'(got[63:0]), AW'(64'h1_0000_0000));
  endtask

  task automatic testWrap();
    logic [AW-1:0] got;
    logic [AW-1:0] acc;
    acc = '0;
    for (int q = 0; q < 8; q++) acc[64*q +: 64] = {32'h7FFF_FFFF, 32'h7FFF_FFFF};
    runOp(1'b0, {32{8'h01}}, {32{8'h01}}, acc, "R8 narrow wrap", got);
    check(got[31:0] == 32'h8000_0007, "R8 narrow value", AW'(got[31:0]), AW'(32'h8000_0007));
    acc = {16{64'h7FFF_FFFF_FFFF_FFFF}};
    runOp(1'b1, {16{16'h0001}}, {16{16'h0001}}, acc, "R8 wide wrap", got);
    check(got[63:0] == 64'h8000_0000_0000_0003, "R8 wide value", AW'(got[63:0]),
          AW'(64'h8000_0000_0000_0003));
  endtask

  task automatic testBackToBack();
    logic [AW-1:0] exp [6];
    for (int i = 0; i < 8; i++) begin
      if (i >= 2) begin
        check(outValid == 1'b1, "R2 stream valid", AW'(outValid), AW'(1));
        check(accOut == exp[i-2], "R2 stream order", accOut, exp[i-2]);
      end
      if (i < 6) begin
        logic [RW-1:0] a, b;
        logic [AW-1:0] acc;
        a = rnd256(); b = rnd256(); acc = rnd1024();
        exp[i] = model(1'(i % 2), a, b, acc);
        modeWide = 1'(i % 2); lhsReg = a; rhsReg = b; accIn = acc; inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end
    check(outValid == 1'b0, "R2 stream end", AW'(outValid), '0);
  endtask

  task automatic testRandom();
    logic [AW-1:0] got;
    for (int i = 0; i < 20; i++)
      runOp(1'(i % 2), rnd256(), rnd256(), rnd1024(), "R3/R6 random", got);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testNarrow();
    testTranspose();
    testPassthrough();
    testWide();
    testCorners();
    testWrap();
    testBackToBack();
    testRandom();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule